// File: doc/BRIEF.md
# Two-Port Shared Word Store with Collision Arbiter

A small on-chip memory that two independent agents, the left port (A) and the right port (B), can use at the same time. Each port has its own request, write enable, address and write data lines. Each port also has a registered read data output and an active-low busy flag. When the two ports address different words, both accesses go ahead in the same cycle. When both requests point at the same word, an arbiter lets one port through and drives the other port's busy flag low. The blocked port is held off for as long as that flag stays low.

The design runs on one clock, and request arrival is judged at each clock edge. The port that was already requesting in the previous cycle, while the other was not, counts as first. Requests that start on the same edge count as a tie, and the left port wins a tie. The same applies to two long-standing requests that converge on one word. A winner keeps its priority for as long as the collision lasts. The loser proceeds in the first cycle in which the winner no longer requests. The flag therefore works as an inverted acknowledge: a port's access completes at the clock edge of any cycle in which it requests and its flag is high.

Top module: `twin_port_ram`

## Requirements
- R1: During and after reset both busy flags are high, both read data outputs are zero, and every memory word reads as zero.
- R2: When only one port requests, or both request different addresses, both busy flags are high and each requested access completes at that clock edge.
- R3: On a same-address request where one port requested in the previous cycle and the other did not, the earlier port keeps its busy flag high and the later port's busy flag is low.
- R4: The two busy flags are never low in the same cycle.
- R5: On a same-address request where neither port or both ports requested in the previous cycle, and there was no collision in the previous cycle, port A wins and port B's busy flag is low. This covers read/read, write/write and read/write.
- R6: While the collision persists from one cycle to the next, the same port keeps winning.
- R7: A write made while the port's busy flag is low does not modify memory.
- R8: A read made while the port's busy flag is low leaves that port's read data output unchanged.
- R9: In the first cycle in which the winner no longer requests, a loser that still requests sees its busy flag high and its access completes.
- R10: An accepted write (we=1) stores its data at the clock edge. An accepted read (we=0) puts the stored word on the read data output after that same edge. The read data output holds its value on idle cycles and on write cycles.
- R11: A port that is not requesting always sees its busy flag high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_req_i | input | 1 | Port A access request |
| a_we_i | input | 1 | Port A write enable (1 write, 0 read) |
| a_addr_i | input | AW | Port A word address |
| a_wdata_i | input | DW | Port A write data |
| a_rdata_o | output | DW | Port A registered read data |
| a_busy_no | output | 1 | Port A busy, active low |
| b_req_i | input | 1 | Port B access request |
| b_we_i | input | 1 | Port B write enable (1 write, 0 read) |
| b_addr_i | input | AW | Port B word address |
| b_wdata_i | input | DW | Port B write data |
| b_rdata_o | output | DW | Port B registered read data |
| b_busy_no | output | 1 | Port B busy, active low |

## Verification
The bench orders arrivals in both directions: B first against A, A first against B, simultaneous starts, and two older requests that drift onto one word. An arbiter that ignored arrival order, or gave the tie to the wrong side, would show a busy flag on the wrong port. Blocked writes are followed by a read of the contended word, so a design that let the loser write would return that loser's data. Blocked reads look for read data that moved when it should have held. After the winner releases, the bench checks in that same cycle that the loser is let through. A design that kept the old winner too long, or swapped winners in the middle of a collision, would keep the wrong port stalled.

// File: rtl/twin_port_pkg.sv
package twin_port_pkg;
  typedef enum logic {SIDE_A = 1'b0, SIDE_B = 1'b1} side_e;
  localparam int unsigned NPORT = 2;
endpackage

// File: rtl/twin_arb.sv
module twin_arb
  import twin_port_pkg::*;
#(
  parameter int unsigned AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          a_req_i,
  input  logic          b_req_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic [AW-1:0] b_addr_i,
  output logic          a_grant_o,
  output logic          b_grant_o,
  output logic          a_busy_no,
  output logic          b_busy_no
);
  logic  a_req_q, b_req_q, coll_q, coll;
  side_e win_q, win_d;

  assign coll = a_req_i && b_req_i && (a_addr_i == b_addr_i);

  always_comb begin
    if (coll_q)                 win_d = win_q;   // winner holds across a lasting collision
    else if (b_req_q && !a_req_q) win_d = SIDE_B;
    else                        win_d = SIDE_A;  // tie or both already pending
  end

  assign a_busy_no = !(coll && win_d == SIDE_B);
  assign b_busy_no = !(coll && win_d == SIDE_A);
  assign a_grant_o = a_req_i && a_busy_no;
  assign b_grant_o = b_req_i && b_busy_no;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_req_q <= 1'b0;
      b_req_q <= 1'b0;
      coll_q  <= 1'b0;
      win_q   <= SIDE_A;
    end else begin
      a_req_q <= a_req_i;
      b_req_q <= b_req_i;
      coll_q  <= coll;
      if (coll) win_q <= win_d;
    end
  end
endmodule

// File: rtl/twin_store.sv
module twin_store
  import twin_port_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NPORT-1:0]           grant_i,
  input  logic [NPORT-1:0]           we_i,
  input  logic [NPORT-1:0][AW-1:0]   addr_i,
  input  logic [NPORT-1:0][DW-1:0]   wdata_i,
  output logic [NPORT-1:0][DW-1:0]   rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  // arbiter guarantees granted writes never share an address
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else begin
      for (int p = 0; p < int'(NPORT); p++)
        if (grant_i[p] && we_i[p]) mem_q[addr_i[p]] <= wdata_i[p];
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    logic [DW-1:0] rd_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       rd_q <= '0;
      else if (grant_i[p] && !we_i[p])   rd_q <= mem_q[addr_i[p]];
    end
    assign rdata_o[p] = rd_q;
  end
endmodule

// File: rtl/twin_port_ram.sv
module twin_port_ram
  import twin_port_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          a_req_i,
  input  logic          a_we_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic [DW-1:0] a_wdata_i,
  output logic [DW-1:0] a_rdata_o,
  output logic          a_busy_no,
  input  logic          b_req_i,
  input  logic          b_we_i,
  input  logic [AW-1:0] b_addr_i,
  input  logic [DW-1:0] b_wdata_i,
  output logic [DW-1:0] b_rdata_o,
  output logic          b_busy_no
);
  logic a_grant, b_grant;
  logic [NPORT-1:0][DW-1:0] rdata;

  twin_arb #(.AW(AW)) u_arb (
    .clk_i, .rst_ni,
    .a_req_i, .b_req_i, .a_addr_i, .b_addr_i,
    .a_grant_o(a_grant), .b_grant_o(b_grant),
    .a_busy_no, .b_busy_no
  );

  twin_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .grant_i({b_grant, a_grant}),
    .we_i({b_we_i, a_we_i}),
    .addr_i({b_addr_i, a_addr_i}),
    .wdata_i({b_wdata_i, a_wdata_i}),
    .rdata_o(rdata)
  );

  assign a_rdata_o = rdata[0];
  assign b_rdata_o = rdata[1];
endmodule

// File: rtl/twin_port_ram_chk.sv
module twin_port_ram_chk #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          a_req_i,
  input logic [AW-1:0] a_addr_i,
  input logic [DW-1:0] a_rdata_o,
  input logic          a_busy_no,
  input logic          b_req_i,
  input logic [AW-1:0] b_addr_i,
  input logic [DW-1:0] b_rdata_o,
  input logic          b_busy_no
);
  logic same;
  assign same = a_req_i && b_req_i && (a_addr_i == b_addr_i);

  a_r4_never_both_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!a_busy_no && !b_busy_no));
  a_r2_distinct_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_req_i && b_req_i && a_addr_i != b_addr_i) |-> (a_busy_no && b_busy_no));
  a_r11_idle_a_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !a_req_i |-> a_busy_no);
  a_r11_idle_b_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !b_req_i |-> b_busy_no);
  a_r3_b_first_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (same && $past(b_req_i) && !$past(a_req_i)) |-> (b_busy_no && !a_busy_no));
  a_r3_a_first_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (same && $past(a_req_i) && !$past(b_req_i)) |-> (a_busy_no && !b_busy_no));
  a_r5_tie_left: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (same && !$past(a_req_i) && !$past(b_req_i)) |-> (a_busy_no && !b_busy_no));
  a_r6_a_stays_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (same && $past(same) && !$past(a_busy_no)) |-> !a_busy_no);
  a_r8_a_read_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_req_i && !a_busy_no) |=> $stable(a_rdata_o));
  a_r8_b_read_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_req_i && !b_busy_no) |=> $stable(b_rdata_o));
endmodule

bind twin_port_ram twin_port_ram_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .a_req_i(a_req_i), .a_addr_i(a_addr_i), .a_rdata_o(a_rdata_o), .a_busy_no(a_busy_no),
  .b_req_i(b_req_i), .b_addr_i(b_addr_i), .b_rdata_o(b_rdata_o), .b_busy_no(b_busy_no)
);

// File: tb/twin_port_ram_test.sv
`timescale 1ns/1ps
module twin_port_ram_test;
  localparam int DW = 16, DEPTH = 16, AW = 4;
  localparam real TCK = 4.0;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic a_req = 0, a_we = 0, b_req = 0, b_we = 0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_wd = '0, b_wd = '0;
  logic [DW-1:0] a_rd, b_rd;
  logic a_busy_n, b_busy_n;

  always #(TCK/2) clk = ~clk;

  twin_port_ram #(.DW(DW), .DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .a_req_i(a_req), .a_we_i(a_we), .a_addr_i(a_addr), .a_wdata_i(a_wd),
    .a_rdata_o(a_rd), .a_busy_no(a_busy_n),
    .b_req_i(b_req), .b_we_i(b_we), .b_addr_i(b_addr), .b_wdata_i(b_wd),
    .b_rdata_o(b_rd), .b_busy_no(b_busy_n)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  int age_a = 0, age_b = 0;          // cycles each port has been requesting
  bit prev_coll = 0, prev_win_b = 0;
  logic [DW-1:0] ref_mem [DEPTH];
  logic [DW-1:0] ref_rd_a = '0, ref_rd_b = '0;

  task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(string tag,
                     bit ar, bit aw, int aa, int ad,
                     bit br, bit bw, int ba, int bd);
    bit coll, win_b, ebusy_a, ebusy_b, ga, gb;
    @(negedge clk);
    a_req = ar; a_we = aw; a_addr = AW'(aa); a_wd = DW'(ad);
    b_req = br; b_we = bw; b_addr = AW'(ba); b_wd = DW'(bd);
    #1;
    coll  = ar && br && (aa == ba);
    if (prev_coll) win_b = prev_win_b;
    else           win_b = (age_b > 0) && (age_a == 0);
    ebusy_a = !(coll && win_b);
    ebusy_b = !(coll && !win_b);
    chk(tag, "a_busy_n", DW'(a_busy_n), DW'(ebusy_a));
    chk(tag, "b_busy_n", DW'(b_busy_n), DW'(ebusy_b));
    chk("R4", "both_busy_low", DW'(!a_busy_n && !b_busy_n), '0);
    ga = ar && ebusy_a;
    gb = br && ebusy_b;
    @(posedge clk);
    if (ga && !aw) ref_rd_a = ref_mem[aa];
    if (gb && !bw) ref_rd_b = ref_mem[ba];
    if (ga && aw) ref_mem[aa] = DW'(ad);
    if (gb && bw) ref_mem[ba] = DW'(bd);
    age_a = ar ? age_a + 1 : 0;
    age_b = br ? age_b + 1 : 0;
    prev_coll  = coll;
    prev_win_b = coll ? win_b : prev_win_b;
    #1;
    chk(tag, "a_rdata", a_rd, ref_rd_a);
    chk(tag, "b_rdata", b_rd, ref_rd_b);
  endtask

  task automatic idle(string tag);
    cyc(tag, 0,0,0,0, 0,0,0,0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "a_busy_n_rst", DW'(a_busy_n), 1);
    chk("R1", "b_busy_n_rst", DW'(b_busy_n), 1);
    chk("R1", "a_rdata_rst", a_rd, '0);
    chk("R1", "b_rdata_rst", b_rd, '0);
    @(negedge clk); rst_ni = 1'b1;

    // R1 memory clear, R2 distinct addresses
    cyc("R1", 1,0,3,0,      1,0,9,0);
    cyc("R2", 1,1,1,'h1111, 1,1,2,'h2222);
    cyc("R2", 1,0,2,0,      1,0,1,0);
    // R10 read data held on write and idle
    cyc("R10", 1,1,5,'h5555, 0,0,0,0);
    idle("R11");
    cyc("R2", 0,0,0,0,      1,0,5,0);

    // R5 read/read tie, R6 hold, R9 release
    idle("R11");
    cyc("R5", 1,0,1,0, 1,0,1,0);
    cyc("R6", 1,0,1,0, 1,0,1,0);
    cyc("R9", 0,0,0,0, 1,0,1,0);

    // R3 write/write: B first, A blocked; R7 blocked write not stored
    idle("R11");
    cyc("R3", 0,0,0,0,      1,1,4,'hBBBB);
    cyc("R3", 1,1,4,'hAAAA, 1,1,4,'hBBBB);
    cyc("R7", 1,1,4,'hAAAA, 1,1,4,'hBBBB);
    idle("R7");
    cyc("R7", 1,0,4,0, 0,0,0,0);

    // R3 read/write: A writes first, B read blocked (R8), then R9
    idle("R11");
    cyc("R3", 1,1,6,'h6666, 0,0,0,0);
    cyc("R8", 1,1,6,'h6677, 1,0,6,0);
    cyc("R8", 1,1,6,'h6688, 1,0,6,0);
    cyc("R9", 0,0,0,0,      1,0,6,0);

    // R5 read/write tie: A reads old, B write blocked
    idle("R11");
    cyc("R5", 1,0,7,0, 1,1,7,'h7777);
    cyc("R9", 0,0,0,0, 1,1,7,'h7777);
    cyc("R10", 1,0,7,0, 0,0,0,0);

    // R5 converging long-standing requests: left wins
    idle("R11");
    cyc("R2", 1,0,8,0, 1,0,9,0);
    cyc("R5", 1,0,8,0, 1,0,8,0);
    cyc("R6", 1,0,8,0, 1,0,8,0);
    cyc("R9", 0,0,0,0, 1,0,8,0);

    // R5 write/write tie, then B re-reads the word
    idle("R11");
    cyc("R5", 1,1,10,'hA0A0, 1,1,10,'hB0B0);
    idle("R11");
    cyc("R7", 0,0,0,0, 1,0,10,0);
    idle("R11");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(TCK * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule